// File: doc/BRIEF.md
# Chip-Enable-Latched Memory Bus Slave

This block is the device-side control logic for a byte-wide parallel memory that behaves like a static RAM at its pins, with two differences: the address is latched when chip enable falls, and every access is followed by a mandatory recovery gap. The block oversamples the active-low chip enable, write enable and output enable pins together with the address and data pins. It sorts each access into one of three kinds: a read, a write chosen at the start (write enable already low when chip enable falls), or a read that turns into a write when write enable falls part-way through. It then runs an internal cycle of fixed length against an inferred register array.

The data bus is driven only with valid read data. Drive waits for the access time even if output enable is already low, and it stops at once when the access becomes a write. A chip-enable fall that arrives too early is ignored and raises a sticky violation flag. The address width, the access length and the recovery length are parameters. With an address width of 15 the array holds 32K bytes; the default keeps the array small.

Top module: `cel_mem_slave`

## Requirements
- R1: On an accepted falling edge of chip enable the address pins are captured. Address pin changes after the capture have no effect on which byte is read or written in that cycle.
- R2: An accepted cycle lasts ACCESS_CYC clocks even if chip enable returns high earlier. A write whose chip enable is released early is still stored, and a second chip-enable fall inside the cycle does not start another access.
- R3: If write enable is low when chip enable falls, the cycle is a write, and dout_en stays 0 for the whole cycle whatever output enable does.
- R4: If write enable falls during a read cycle while chip enable is low, dout_en drops within 3 clocks of the pin change and the cycle becomes a write.
- R5: A write cycle stores one byte, at the first rising edge of write enable or of chip enable. The stored value is the data sampled at that edge, and later data pin changes are not stored.
- R6: dout_en is 1 only in a read cycle whose access time has elapsed, with output enable, chip enable low and write enable high. The first drive comes no earlier than ACCESS_CYC clocks after the chip-enable fall at the pin. dout is 0 whenever dout_en is 0.
- R7: Read data stays driven while output enable and chip enable stay low. dout_en falls within 3 clocks after either pin goes high.
- R8: A chip-enable fall during a running cycle or during recovery is ignored (no access, no drive) and sets viol. viol stays 1 until reset.
- R9: After a cycle ends with chip enable high, PRECHARGE_CYC clocks of recovery pass before a new fall is accepted. At the pins, chip enable held high for PRECHARGE_CYC+1 clocks after a completed access is enough for a clean new access.
- R10: While rst is high and after it, dout_en, dout and viol are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| viol | output | 1 | Sticky timing violation flag |

## Verification
The assertions look at the synchronised copies of the pins. They take for granted that each pin level lasts at least one clock, so that every edge is seen, and that data and address stay steady for about three clocks around the edges they qualify. The bench drives every input on the falling clock edge and holds each level for at least one full clock. It keeps din steady for three clocks after write enable or chip enable rises, and it changes the address only after the capture. The one-clock chip-enable pulse and the short recovery gaps are applied on purpose, to reach the violation path.

// File: rtl/cel_pkg.sv
package cel_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_PRE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WR_CE = 2'd1,
        K_WR_WE = 2'd2
    } kind_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_t;

    typedef struct packed {
        logic ce_fall;
        logic ce_rise;
        logic we_fall;
        logic we_rise;
    } edges_t;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

    function automatic edges_t find_edges(input logic ce_prev, input logic ce_now,
                                          input logic we_prev, input logic we_now);
        edges_t e;
        e.ce_fall = ce_prev & ~ce_now;
        e.ce_rise = ~ce_prev & ce_now;
        e.we_fall = we_prev & ~we_now;
        e.we_rise = ~we_prev & we_now;
        return e;
    endfunction

endpackage

// File: rtl/cel_sync.sv
module cel_sync #(
    parameter int            W    = 1,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st1;
    logic [W-1:0] st2;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= INIT;
            st2 <= INIT;
        end else begin
            st1 <= d;
            st2 <= st1;
        end
    end

    assign q = st2;
endmodule

// File: rtl/cel_seq.sv
module cel_seq
    import cel_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int ACCESS_CYC    = 4,
    parameter int PRECHARGE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_s,
    input  logic              we_s,
    input  edges_t            ev,
    input  logic [ADDR_W-1:0] addr_s,
    output phase_e            phase,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr_q,
    output logic              done,
    output logic              released,
    output logic              commit,
    output logic              rd_load,
    output logic              viol
);
    localparam int CW = cnt_width(ACCESS_CYC, PRECHARGE_CYC);
    localparam logic [CW-1:0] ACC_LAST = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRECHARGE_CYC - 1);

    logic [CW-1:0] cnt;
    logic          wr_done;

    assign commit  = (phase == PH_RUN) && (kind != K_READ) && !wr_done &&
                     (ev.we_rise || ev.ce_rise);
    assign rd_load = (phase == PH_RUN) && !done && (cnt == ACC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            kind     <= K_READ;
            addr_q   <= '0;
            cnt      <= '0;
            done     <= 1'b0;
            released <= 1'b0;
            wr_done  <= 1'b0;
            viol     <= 1'b0;
        end else begin
            if (ev.ce_fall && phase != PH_IDLE) begin
                viol <= 1'b1;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (ev.ce_fall) begin
                        phase    <= PH_RUN;
                        addr_q   <= addr_s;
                        kind     <= we_s ? K_READ : K_WR_CE;
                        cnt      <= '0;
                        done     <= 1'b0;
                        released <= 1'b0;
                        wr_done  <= 1'b0;
                    end
                end
                PH_RUN: begin
                    if (!done) begin
                        if (cnt == ACC_LAST) begin
                            done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    if (ev.ce_rise) begin
                        released <= 1'b1;
                    end
                    if (kind == K_READ && ev.we_fall && !released) begin
                        kind <= K_WR_WE;
                    end
                    if (commit) begin
                        wr_done <= 1'b1;
                    end
                    if (done && (released || ce_s)) begin
                        phase <= PH_PRE;
                        cnt   <= '0;
                    end
                end
                PH_PRE: begin
                    if (cnt == PRE_LAST) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cel_array.sv
module cel_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/cel_outgate.sv
module cel_outgate
    import cel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  kind_e             kind,
    input  logic              done,
    input  logic              released,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic [DATA_W-1:0] held;
    logic              drive_q;
    logic              drive_ok;

    assign drive_ok = (phase == PH_RUN) && (kind == K_READ) && done && !released &&
                      !ce_s && we_s && !oe_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            drive_q <= 1'b0;
        end else begin
            if (rd_load) begin
                held <= rdata;
            end
            drive_q <= drive_ok;
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_gate
        assign dout[b] = held[b] & drive_q;
    end

    assign dout_en = drive_q;
endmodule

// File: rtl/cel_mem_slave.sv
module cel_mem_slave
    import cel_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int ACCESS_CYC    = 4,
    parameter int PRECHARGE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              viol
);
    ctl_t              ctl_raw;
    logic [2:0]        ctl_sv;
    ctl_t              ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              ce_prev;
    logic              we_prev;
    edges_t            ev;

    phase_e            phase;
    kind_e             kind;
    logic [ADDR_W-1:0] addr_q;
    logic              done;
    logic              released;
    logic              commit;
    logic              rd_load;
    logic [DATA_W-1:0] rdata;
    logic              ce_fall;
    logic              oe_s;

    assign ctl_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

    cel_sync #(.W(3), .INIT(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_sv)
    );
    cel_sync #(.W(ADDR_W)) u_sync_addr (
        .clk(clk), .rst(rst), .d(addr), .q(addr_s)
    );
    cel_sync #(.W(DATA_W)) u_sync_din (
        .clk(clk), .rst(rst), .d(din), .q(din_s)
    );

    assign ctl_s = ctl_t'(ctl_sv);
    assign oe_s  = ctl_s.oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev <= 1'b1;
            we_prev <= 1'b1;
        end else begin
            ce_prev <= ctl_s.ce_n;
            we_prev <= ctl_s.we_n;
        end
    end

    assign ev      = find_edges(ce_prev, ctl_s.ce_n, we_prev, ctl_s.we_n);
    assign ce_fall = ev.ce_fall;

    cel_seq #(
        .ADDR_W(ADDR_W), .ACCESS_CYC(ACCESS_CYC), .PRECHARGE_CYC(PRECHARGE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .ce_s(ctl_s.ce_n), .we_s(ctl_s.we_n), .ev(ev),
        .addr_s(addr_s), .phase(phase), .kind(kind), .addr_q(addr_q),
        .done(done), .released(released), .commit(commit), .rd_load(rd_load),
        .viol(viol)
    );

    cel_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(commit), .addr(addr_q), .wdata(din_s), .rdata(rdata)
    );

    cel_outgate #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .phase(phase), .kind(kind), .done(done),
        .released(released), .ce_s(ctl_s.ce_n), .we_s(ctl_s.we_n), .oe_s(oe_s),
        .rd_load(rd_load), .rdata(rdata), .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: rtl/cel_mem_chk.sv
module cel_mem_chk
    import cel_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input phase_e        phase,
    input kind_e         kind,
    input logic          done,
    input logic          commit,
    input logic          ce_fall,
    input logic          oe_s,
    input logic          dout_en,
    input logic          viol,
    input logic [AW-1:0] addr_q
);
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase == PH_RUN)) |-> $stable(addr_q)); // R1

    AST_RUN_TO_END: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && !done) |=> (phase == PH_RUN)); // R2

    AST_CE_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && kind == K_WR_CE) |-> !dout_en); // R3

    AST_WE_WRITE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (kind == K_WR_WE) |=> !dout_en); // R4

    AST_COMMIT_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit |-> (phase == PH_RUN && kind != K_READ)); // R5

    AST_DRIVE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> done); // R6

    AST_OE_HIGH_RELEASE: assert property (@(posedge clk) disable iff (rst)
        oe_s |=> !dout_en); // R7

    AST_PRE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE) |=> !dout_en); // R7

    AST_BAD_FALL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ce_fall && phase != PH_IDLE) |=> viol); // R8

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol); // R8

    AST_PRE_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE) |=> (phase != PH_RUN)); // R9
endmodule

bind cel_mem_slave cel_mem_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .phase(phase), .kind(kind), .done(done),
    .commit(commit), .ce_fall(ce_fall), .oe_s(oe_s), .dout_en(dout_en),
    .viol(viol), .addr_q(addr_q)
);

// File: tb/tb_cel_mem_slave.sv
module tb_cel_mem_slave;
    localparam int ACC = 4;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic       viol;

    int nchk = 0;
    int nfail = 0;

    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       drive_prev = 1'b0;
    logic [7:0] exp_v;
    string      exp_t;

    always #10 clk = ~clk;

    cel_mem_slave #(
        .ADDR_W(8), .DATA_W(8), .ACCESS_CYC(ACC), .PRECHARGE_CYC(PRE)
    ) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .viol(viol)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every new drive pops one expected byte.
    always @(negedge clk) begin
        if (!rst && dout_en && !drive_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "drive with no read pending", int'(dout), 0);
            end else begin
                exp_v = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                check(dout === exp_v, exp_t, "read data", int'(dout), int'(exp_v));
            end
        end
        if (!rst && !dout_en && dout != 8'h00) begin
            check(1'b0, "R6", "dout nonzero while undriven", int'(dout), 0);
        end
        drive_prev <= dout_en;
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ce(input logic [7:0] a, input logic [7:0] d);
        bit drove;
        drove = 1'b0;
        addr = a; din = d; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        for (int i = 0; i < ACC + 6; i++) begin
            @(negedge clk);
            if (i == 2) addr = ~a;
            if (dout_en) drove = 1'b1;
        end
        ce_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (dout_en) drove = 1'b1;
        end
        we_n = 1'b1; din = ~d; oe_n = 1'b1;
        check(!drove, "R3", "drive during chip-enable write", int'(drove), 0);
        model[a] = d;
        ticks(PRE + 6);
    endtask

    // Read with output enable low; gap = clocks chip enable stays high afterwards.
    task automatic do_read(input logic [7:0] a, input string tag, input int gap);
        int  n;
        bit  seen;
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
        addr = a; we_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        n = 0; seen = 1'b0;
        for (int i = 0; i < ACC + 10 && !seen; i++) begin
            @(negedge clk);
            n++;
            if (i == 2) addr = ~a;
            if (dout_en) seen = 1'b1;
        end
        check(seen && n >= ACC && n <= ACC + 5, "R6", "drive latency", n, ACC + 4);
        ticks(3);
        check(dout_en == 1'b1, "R7", "drive held while enables low", int'(dout_en), 1);
        ce_n = 1'b1;
        n = 0;
        for (int i = 0; i < 8 && dout_en; i++) begin
            @(negedge clk);
            n++;
        end
        check(!dout_en && n <= 3, "R7", "release after chip enable high", n, 3);
        oe_n = 1'b1;
        ticks(gap - n);
    endtask

    initial begin
        int  n;
        bit  drove;

        ticks(5);
        check(dout_en == 1'b0, "R10", "dout_en in reset", int'(dout_en), 0);
        check(viol == 1'b0, "R10", "viol in reset", int'(viol), 0);
        rst = 1'b0;
        ticks(4);
        check(dout == 8'h00 && !dout_en, "R10", "outputs after reset", int'(dout), 0);

        // R3, R1, R5: chip-enable controlled writes with OE low and address scrambled.
        write_ce(8'h10, 8'hA5);
        write_ce(8'h11, 8'h5A);
        write_ce(8'hFF, 8'h3C);
        write_ce(8'h00, 8'hC3);

        // R1, R5, R6: reads back through the scoreboard.
        do_read(8'h10, "R1", PRE + 6);
        do_read(8'h11, "R5", PRE + 6);
        do_read(8'hFF, "R1", PRE + 6);
        do_read(8'h00, "R5", PRE + 6);

        // R4: read turns into a write when write enable falls.
        exp_q.push_back(model[8'h10]);
        tag_q.push_back("R4");
        addr = 8'h10; we_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        ticks(ACC + 8);
        check(dout_en == 1'b1, "R4", "read drive before write enable", int'(dout_en), 1);
        we_n = 1'b0; din = 8'h77;
        n = 0;
        for (int i = 0; i < 8 && dout_en; i++) begin
            @(negedge clk);
            n++;
        end
        check(!dout_en && n <= 3, "R4", "drive stops after write enable falls", n, 3);
        ticks(2);
        we_n = 1'b1;
        ticks(3);
        din = 8'h99;                      // R5: not stored
        ticks(3);
        check(dout_en == 1'b0, "R4", "no drive after conversion", int'(dout_en), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        model[8'h10] = 8'h77;
        ticks(PRE + 6);
        do_read(8'h10, "R4", PRE + 6);

        // R2, R5: write released early by chip enable still stores.
        addr = 8'h20; din = 8'h42; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        ticks(2);
        ce_n = 1'b1;
        ticks(3);
        we_n = 1'b1; din = 8'h00;
        model[8'h20] = 8'h42;
        ticks(ACC + PRE + 8);
        do_read(8'h20, "R2", PRE + 6);

        // R6: OE high hides the data; lowering it later drives valid data.
        addr = 8'h11; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        drove = 1'b0;
        for (int i = 0; i < ACC + 8; i++) begin
            @(negedge clk);
            if (dout_en) drove = 1'b1;
        end
        check(!drove, "R6", "no drive with OE high", int'(drove), 0);
        exp_q.push_back(model[8'h11]);
        tag_q.push_back("R6");
        oe_n = 1'b0;
        ticks(5);
        check(dout_en == 1'b1, "R6", "drive after late OE", int'(dout_en), 1);
        oe_n = 1'b1;
        n = 0;
        for (int i = 0; i < 8 && dout_en; i++) begin
            @(negedge clk);
            n++;
        end
        check(!dout_en && n <= 3, "R7", "release after OE high", n, 3);
        ce_n = 1'b1;
        ticks(PRE + 6);

        // R9: chip enable high exactly PRE+1 clocks is accepted.
        do_read(8'hFF, "R9", PRE + 1);
        do_read(8'h00, "R9", PRE);
        check(viol == 1'b0, "R9", "no violation at minimum recovery", int'(viol), 0);

        // R8: fall after only PRE clocks of recovery is ignored and flagged.
        addr = 8'h10; we_n = 1'b1; oe_n = 1'b0;
        do_read(8'h11, "R8", PRE);
        ce_n = 1'b0;
        drove = 1'b0;
        for (int i = 0; i < ACC + 8; i++) begin
            @(negedge clk);
            if (dout_en) drove = 1'b1;
        end
        check(viol == 1'b1, "R8", "violation after short recovery", int'(viol), 1);
        check(!drove, "R8", "ignored fall gives no access", int'(drove), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        ticks(PRE + 6);
        check(viol == 1'b1, "R8", "violation sticky", int'(viol), 1);
        rst = 1'b1;
        ticks(2);
        rst = 1'b0;
        ticks(2);
        check(viol == 1'b0, "R8", "violation cleared by reset", int'(viol), 0);

        // R2, R8: second fall inside a running cycle.
        addr = 8'h20; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        ticks(2);
        ce_n = 1'b1;
        ticks(1);
        ce_n = 1'b0;
        ticks(ACC + 6);
        check(viol == 1'b1, "R8", "violation on fall in running cycle", int'(viol), 1);
        oe_n = 1'b0;
        ticks(4);
        check(dout_en == 1'b0, "R2", "no new access from fall in cycle", int'(dout_en), 0);
        ce_n = 1'b1; oe_n = 1'b1;
        ticks(PRE + 6);
        do_read(8'h20, "R2", PRE + 6);

        check(exp_q.size() == 0, "R6", "all expected reads seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule